// File: doc/BRIEF.md
# Checksum Erasure Decoder for Three 2-of-4 Channels

This block sits behind three parallel 4-wire channels. Each channel carries a constant-weight code word with exactly two ones. Two channels carry the data groups and the third carries a modulo-3 checksum of them. Each valid word belongs to one of three subsets, which gives its group digit, and its member within the subset gives a selector bit. The decoder resolves every word into a group and a selector and flags any word whose weight is wrong. When exactly one channel has a wrong weight, that channel is treated as an erasure. The decoder rebuilds the missing group from the checksum and then picks the subset member nearest to the received word.

Any single wire flip on any of the twelve wires is repaired, and the original 6-bit value comes back with a repair flag. Patterns the code cannot resolve raise an unrecoverable flag and force the data to zero. These patterns are several bad channels, a failed checksum, an impossible digit pair, or a rebuilt subset whose two members are equally close to the received word. One word is accepted per strobed cycle, and the result is registered one cycle later.

Top module: `cw3_erasure_dec`

## Requirements
- R1: `out_valid` rises on the clock edge after the edge that samples `in_valid` high, and only then. After reset all outputs are zero.
- R2: Input wires [11:8] carry the high data group, [7:4] the low data group and [3:0] the checksum group. Subsets are group 0 = {0011, 1100}, group 1 = {0101, 1010} and group 2 = {0110, 1001}, where the first member has selector 0 and the second has selector 1. Suppose all three words are valid, the checksum group equals (high + low) mod 3, and high*3+low is at most 7. Then `out_data[5:3]` is high*3+low in binary, and `out_data[2:0]` is the selectors of the high, low and checksum channels, in that order from bit 2 down. Both flags are 0.
- R3: A word counts as invalid exactly when its number of ones is not 2.
- R4: When only one data channel is invalid, its group is rebuilt as (checksum − other data group) mod 3.
- R5: When only the checksum channel is invalid, its group is rebuilt as (high + low) mod 3.
- R6: The repaired word is the member of the rebuilt subset at the smaller Hamming distance from the received word. Any single-bit error on any of the 12 wires returns the original data with `out_corrected`=1 and `out_uncorr`=0.
- R7: Two or more invalid words give `out_uncorr`=1, `out_corrected`=0 and `out_data`=0.
- R8: Three valid words that fail the checksum give `out_uncorr`=1 and `out_data`=0.
- R9: Data digits high=2 and low=2 give `out_uncorr`=1 and `out_data`=0.
- R10: A single invalid word at equal distance from both members of its rebuilt subset (weight 0 or 4) gives `out_uncorr`=1 and `out_data`=0.
- R11: While `in_valid` is low, `in_word` is ignored: `out_data` and both flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe marking a word on `in_word` |
| in_word | input | 12 | Three received 4-wire code words |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 6 | Recovered data value |
| out_corrected | output | 1 | One invalid word was repaired |
| out_uncorr | output | 1 | Word could not be decoded |

## Verification
Each word is driven for one cycle at a falling edge. The rising edge that follows samples it, so its data and both flags, together with `out_valid`, are due at the next falling edge, one cycle later. The bench queues the expected result as it drives each word. It pops one entry whenever it sees `out_valid` at a falling edge, so each result is compared in exactly the cycle it is due. A result that shows up without a queued entry, or an entry left over at the end, is reported against the latency requirement. During idle cycles the bench drives garbage on `in_word` and checks at each falling edge that the data output keeps its last value.

// File: rtl/cw3_pkg.sv
package cw3_pkg;
   localparam int CODE_W = 4;
   localparam int CODE_ONES = 2;

   typedef logic [1:0] grp_t;

   // first member of each subset; the second member is its complement
   function automatic logic [CODE_W-1:0] subset_base(grp_t g);
      case (g)
         2'd0:    return 4'b0011;
         2'd1:    return 4'b0101;
         default: return 4'b0110;
      endcase
   endfunction

   function automatic grp_t mod3_add(grp_t a, grp_t b);
      logic [2:0] s;
      s = {1'b0, a} + {1'b0, b};
      return (s >= 3'd3) ? grp_t'(s - 3'd3) : grp_t'(s);
   endfunction

   function automatic grp_t mod3_sub(grp_t a, grp_t b);
      logic [2:0] s;
      s = {1'b0, a} + 3'd3 - {1'b0, b};
      return (s >= 3'd3) ? grp_t'(s - 3'd3) : grp_t'(s);
   endfunction
endpackage

// File: rtl/cw_resolve.sv
module cw_resolve
   import cw3_pkg::*;
#(
   parameter int CW_W    = CODE_W,
   parameter int CW_ONES = CODE_ONES
) (
   input  logic [CW_W-1:0] word,
   output logic            ok,
   output grp_t            grp,
   output logic            sel
);
   logic [CW_W-1:0] canon;

   always_comb begin
      ok    = ($countones(word) == CW_ONES);
      sel   = word[CW_W-1];
      canon = word[CW_W-1] ? ~word : word;
      case (canon)
         4'b0011: grp = 2'd0;
         4'b0101: grp = 2'd1;
         4'b0110: grp = 2'd2;
         default: grp = 2'd0;
      endcase
   end
endmodule

// File: rtl/cw_fixer.sv
module cw_fixer
   import cw3_pkg::*;
#(
   parameter int CW_W = CODE_W
) (
   input  logic [CW_W-1:0] word,
   input  grp_t            grp,
   output logic            sel,
   output logic            tie
);
   logic [CW_W-1:0] cand0;
   int              dist0;
   int              dist1;

   always_comb begin
      cand0 = subset_base(grp);
      dist0 = $countones(word ^ cand0);
      dist1 = $countones(word ^ ~cand0);
      sel   = (dist1 < dist0);
      tie   = (dist1 == dist0);
   end
endmodule

// File: rtl/cw3_erasure_dec.sv
module cw3_erasure_dec
   import cw3_pkg::*;
#(
   parameter int CW_W    = CODE_W,
   parameter int CW_ONES = CODE_ONES,
   parameter int NCH     = 3,
   parameter int DATA_W  = 6,
   localparam int IN_W   = NCH * CW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_word,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_corrected,
   output logic              out_uncorr
);
   localparam int CH_P  = 0;
   localparam int CH_LO = 1;
   localparam int CH_HI = 2;

   if (CW_W != 4) begin : g_bad_width
      $error("cw3_erasure_dec: code word width must be 4");
   end
   if (CW_ONES != 2) begin : g_bad_weight
      $error("cw3_erasure_dec: code weight must be 2");
   end
   if (NCH != 3) begin : g_bad_nch
      $error("cw3_erasure_dec: exactly three channels supported");
   end
   if (DATA_W != 6) begin : g_bad_data
      $error("cw3_erasure_dec: data width must be 6");
   end

   logic [NCH-1:0] ch_ok;
   logic [NCH-1:0] ch_sel;
   grp_t           ch_grp [NCH];

   for (genvar ch = 0; ch < NCH; ch++) begin : g_res
      cw_resolve #(.CW_W(CW_W), .CW_ONES(CW_ONES)) u_res (
         .word (in_word[ch*CW_W +: CW_W]),
         .ok   (ch_ok[ch]),
         .grp  (ch_grp[ch]),
         .sel  (ch_sel[ch])
      );
   end

   int              n_bad;
   int              bad_idx;
   logic [CW_W-1:0] bad_word;
   grp_t            rebuilt;
   logic            fix_sel;
   logic            fix_tie;

   always_comb begin
      n_bad    = NCH - $countones(ch_ok);
      bad_idx  = 0;
      bad_word = '0;
      for (int i = 0; i < NCH; i++) begin
         if (!ch_ok[i]) begin
            bad_idx  = i;
            bad_word = in_word[i*CW_W +: CW_W];
         end
      end
      case (bad_idx)
         CH_HI:   rebuilt = mod3_sub(ch_grp[CH_P], ch_grp[CH_LO]);
         CH_LO:   rebuilt = mod3_sub(ch_grp[CH_P], ch_grp[CH_HI]);
         default: rebuilt = mod3_add(ch_grp[CH_HI], ch_grp[CH_LO]);
      endcase
   end

   cw_fixer #(.CW_W(CW_W)) u_fix (
      .word (bad_word),
      .grp  (rebuilt),
      .sel  (fix_sel),
      .tie  (fix_tie)
   );

   grp_t              fin_grp [NCH];
   logic [NCH-1:0]    fin_sel;
   logic [3:0]        digits;
   logic              sum_ok;
   logic              unc_c;
   logic              corr_c;
   logic [DATA_W-1:0] data_c;

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         fin_grp[i] = ch_grp[i];
         fin_sel[i] = ch_sel[i];
         if (n_bad == 1 && i == bad_idx) begin
            fin_grp[i] = rebuilt;
            fin_sel[i] = fix_sel;
         end
      end
      digits = {2'b00, fin_grp[CH_HI]} * 4'd3 + {2'b00, fin_grp[CH_LO]};
      sum_ok = (mod3_add(fin_grp[CH_HI], fin_grp[CH_LO]) == fin_grp[CH_P]);
      unc_c  = (n_bad > 1) || (n_bad == 0 && !sum_ok) || digits[3]
               || (n_bad == 1 && fix_tie);
      corr_c = (n_bad == 1) && !unc_c;
      data_c = unc_c ? '0
               : {digits[2:0], fin_sel[CH_HI], fin_sel[CH_LO], fin_sel[CH_P]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_data      <= '0;
         out_corrected <= 1'b0;
         out_uncorr    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data      <= data_c;
            out_corrected <= corr_c;
            out_uncorr    <= unc_c;
         end
      end
   end
endmodule

// File: rtl/cw3_erasure_dec_chk.sv
module cw3_erasure_dec_chk #(
   parameter int CW_W    = 4,
   parameter int CW_ONES = 2,
   parameter int NCH     = 3,
   parameter int DATA_W  = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [NCH*CW_W-1:0]  in_word,
   input logic                 out_valid,
   input logic [DATA_W-1:0]    out_data,
   input logic                 out_corrected,
   input logic                 out_uncorr
);
   logic seen;
   int   nbad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   always_comb begin
      nbad = 0;
      for (int i = 0; i < NCH; i++)
         if ($countones(in_word[i*CW_W +: CW_W]) != CW_ONES) nbad++;
   end

   // R1
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      out_valid == $past(in_valid));

   // R6
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_corrected && out_uncorr));

   // R7
   uncorr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_uncorr |-> (out_data == '0));

   // R7
   multi_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && nbad >= 2) |=> (out_uncorr && !out_corrected));

   // R2
   clean_nocorr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && nbad == 0) |=> !out_corrected);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      !in_valid |=> ($stable(out_data) && !out_valid));
endmodule

bind cw3_erasure_dec cw3_erasure_dec_chk #(
   .CW_W(CW_W), .CW_ONES(CW_ONES), .NCH(NCH), .DATA_W(DATA_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
   .out_valid(out_valid), .out_data(out_data),
   .out_corrected(out_corrected), .out_uncorr(out_uncorr)
);

// File: tb/test_cw3_erasure_dec.sv
`timescale 1ns/1ps
module test_cw3_erasure_dec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] in_word = '0;
   logic        out_valid;
   logic [5:0]  out_data;
   logic        out_corrected;
   logic        out_uncorr;

   int checks = 0;
   int fails  = 0;

   logic [7:0] q_exp[$];
   string      q_req[$];
   logic [5:0] last_data;
   bit         have_last = 0;

   always #4 clk = ~clk;

   cw3_erasure_dec i_cw3_erasure_dec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid), .out_data(out_data),
      .out_corrected(out_corrected), .out_uncorr(out_uncorr)
   );

   function automatic logic [3:0] mem(int g, bit s);
      logic [3:0] b;
      b = (g == 0) ? 4'b0011 : (g == 1) ? 4'b0101 : 4'b0110;
      return s ? ~b : b;
   endfunction

   function automatic logic [11:0] enc(logic [5:0] d);
      int v, hi, lo;
      v  = int'(d[5:3]);
      hi = v / 3;
      lo = v % 3;
      return {mem(hi, d[2]), mem(lo, d[1]), mem((hi + lo) % 3, d[0])};
   endfunction

   task automatic send(input logic [11:0] w, input logic [5:0] d,
                       input bit c, input bit u, input string r);
      @(negedge clk);
      in_word  = w;
      in_valid = 1'b1;
      q_exp.push_back({c, u, d});
      q_req.push_back(r);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_word  = 12'hFFF ^ 12'(i * 37);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            checks++;
            if (q_exp.size() == 0) begin
               fails++;
               $display("FAIL R1: result without pending input, got d=%b expected none", out_data);
            end else begin
               logic [7:0] e;
               string      r;
               e = q_exp.pop_front();
               r = q_req.pop_front();
               if ({out_corrected, out_uncorr, out_data} !== e) begin
                  fails++;
                  $display("FAIL %s: got c=%0b u=%0b d=%b expected c=%0b u=%0b d=%b",
                           r, out_corrected, out_uncorr, out_data, e[7], e[6], e[5:0]);
               end
            end
            last_data = out_data;
            have_last = 1;
         end else if (have_last) begin
            checks++;
            if (out_data !== last_data) begin
               fails++;
               $display("FAIL R11: idle data changed, got %b expected %b", out_data, last_data);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [11:0] w;
      repeat (3) @(negedge clk);
      checks++;
      if ({out_valid, out_corrected, out_uncorr, out_data} !== 9'b0) begin
         fails++;
         $display("FAIL R1: reset state got v=%0b c=%0b u=%0b d=%b expected all zero",
                  out_valid, out_corrected, out_uncorr, out_data);
      end
      rst_n = 1'b1;
      idle(2);

      // R2: clean words
      for (int d = 0; d < 64; d++) send(enc(6'(d)), 6'(d), 0, 0, "R2");
      idle(2);

      // R4 R5 R6: every single wire flip
      for (int d = 0; d < 64; d++)
         for (int b = 0; b < 12; b++)
            send(enc(6'(d)) ^ (12'b1 << b), 6'(d), 1, 0, (b < 4) ? "R5 R6" : "R4 R6");

      // R4 R6: received 1101 in the high channel repairs to 1001
      send(12'b1101_0101_1100, 6'b111101, 1, 0, "R4 R6");
      idle(3);

      // R7 / R3: several invalid channels
      foreach (q_exp[i]) ;
      for (int d = 0; d < 64; d += 9) begin
         send(enc(6'(d)) ^ 12'h011, 6'd0, 0, 1, "R7");
         send(enc(6'(d)) ^ 12'h220, 6'd0, 0, 1, "R7");
         send(enc(6'(d)) ^ 12'h111, 6'd0, 0, 1, "R3 R7");
      end

      // R8: checksum mismatch with all words valid
      for (int d = 0; d < 64; d += 13) begin
         int hi, lo;
         hi = int'(d[5:3]) / 3;
         lo = int'(d[5:3]) % 3;
         w = enc(6'(d));
         w[3:0] = mem(((hi + lo) % 3 + 1) % 3, 1'b0);
         send(w, 6'd0, 0, 1, "R8");
      end

      // R9: digits 2,2 with consistent checksum
      send({mem(2, 0), mem(2, 1), mem(1, 0)}, 6'd0, 0, 1, "R9");
      send({mem(2, 1), mem(2, 1), mem(1, 1)}, 6'd0, 0, 1, "R9");

      // R10: weight 0 or 4 in a single channel
      w = enc(6'b010110); w[11:8] = 4'b0000;
      send(w, 6'd0, 0, 1, "R3 R10");
      w = enc(6'b010110); w[7:4] = 4'b1111;
      send(w, 6'd0, 0, 1, "R3 R10");
      w = enc(6'b101011); w[3:0] = 4'b0000;
      send(w, 6'd0, 0, 1, "R3 R10");

      // R11: garbage while idle, then a normal word
      idle(5);
      send(enc(6'b100111), 6'b100111, 0, 0, "R11 R2");
      idle(4);

      checks++;
      if (q_exp.size() != 0) begin
         fails++;
         $display("FAIL R1: %0d results missing, expected 0", q_exp.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule